// File: doc/BRIEF.md
# Multiplexed VFD Grid Dimming Sequencer

This block drives a vacuum fluorescent display that runs two or three grids in turn. It divides the oscillator clock down to a bit-time tick, and counts a fixed slot of bit times for each grid. It rotates an active-low strobe across the grids. Inside each slot it opens a segment-enable window whose length in bit times follows a 10-bit brightness word. A separate grid index output tells a downstream multiplexer which segment latch should drive the anode pins during the current slot.

The grid count is chosen live by a select pin, which is read at every slot boundary. The brightness word is also latched only at a slot boundary, so no slot ever gets a cut-short pulse. The window is capped so that the last eight bit times of every slot stay dark. A low level on the blank input turns the segment window off at once and leaves the grid strobes running.

Top module: `vfd_grid_dimmer`

## Requirements
- R1: One bit time is four `clk` cycles, and one grid slot is 1024 bit times (4096 cycles). After reset is released, the first slot covers cycles 0 to 4095, counting the rising edges with `rst` low.
- R2: With `duplex_sel` low (three grids), the slots visit grid 1, grid 2, grid 3, then return to grid 1.
- R3: With `duplex_sel` high (two grids), the slots alternate between grid 1 and grid 2, and `grid_n[2]` stays high.
- R4: `grid_n` is active low and has exactly one bit low. The bits are grid 1 = bit 0, grid 2 = bit 1, grid 3 = bit 2. `grid_idx` reads 0, 1 or 2 for grid 1, 2 or 3.
- R5: During reset and in the cycle after it, `grid_n` = 3'b110, `grid_idx` = 0 and `seg_en` = 0. The latched duty is 0, so the first slot after reset is fully dark.
- R6: In a slot with latched duty D, `seg_en` is high for bit positions 0 to D-1 of the slot and low from position D onward.
- R7: A brightness value of 1016 or more is latched as 1016, so positions 1016 to 1023 of every slot are always dark.
- R8: A brightness value of 0 keeps `seg_en` low for the whole slot.
- R9: `dim_level` is sampled only at the clock edge that starts a new slot. A change made in the middle of a slot has no effect until the next slot.
- R10: While `blank_n` is low, `seg_en` is low in the same cycle. The grid strobes keep rotating.
- R11: `duplex_sel` is read at the boundary that leaves grid 2. Changing it in the middle of a slot changes the rotation from the next boundary on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| duplex_sel | input | 1 | 1: two grids, 0: three grids |
| dim_level | input | 10 | Brightness word, LSB = 1 bit time |
| blank_n | input | 1 | Low forces the segment window off |
| grid_n | output | 3 | Active-low grid strobes, bit 0 = grid 1 |
| seg_en | output | 1 | Segment enable window |
| grid_idx | output | 2 | Index of the active grid (0 to 2) |

## Verification
Every result is tied to a count of rising edges since reset was released. Bit position p of slot s occupies edges s*4096+4p through s*4096+4p+3, and each expectation is sampled on the falling edge in the middle of that four-cycle window. The scoreboard keys every expected item to that edge count and compares it only there.

Inputs change one time unit after a rising edge. A brightness change therefore shows up only when the following slot begins. A change to `blank_n` shows up on `seg_en` at the very next falling edge, because the blank path has no register in it.

// File: rtl/vfd_dim_pkg.sv
package vfd_dim_pkg;

    // Oscillator clocks per display bit time
    localparam int unsigned OSC_PER_BIT = 4;
    // log2 of the bit times per grid slot
    localparam int unsigned SLOT_W      = 10;
    // Bit times at the end of a slot that are always dark
    localparam int unsigned DARK_GAP    = 8;

    typedef enum logic [1:0] {
        GSEL_1 = 2'd0,
        GSEL_2 = 2'd1,
        GSEL_3 = 2'd2
    } grid_sel_e;

    typedef struct packed {
        logic bit_tick;
        logic slot_end;
    } slot_evt_t;

    function automatic logic [2:0] grid_strobe_n(grid_sel_e g);
        logic [2:0] s;
        case (g)
            GSEL_1:  s = 3'b110;
            GSEL_2:  s = 3'b101;
            GSEL_3:  s = 3'b011;
            default: s = 3'b110;
        endcase
        return s;
    endfunction

    function automatic grid_sel_e next_grid(grid_sel_e g, logic two_grids);
        grid_sel_e n;
        case (g)
            GSEL_1:  n = GSEL_2;
            GSEL_2:  n = two_grids ? GSEL_1 : GSEL_3;
            default: n = GSEL_1;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/vfd_bit_prescaler.sv
module vfd_bit_prescaler #(
    parameter int unsigned DIV = vfd_dim_pkg::OSC_PER_BIT
) (
    input  logic clk,
    input  logic rst,
    output logic bit_tick
);
    generate
        if (DIV <= 1) begin : g_nodiv
            assign bit_tick = 1'b1;
        end else begin : g_div
            localparam int unsigned CW = $clog2(DIV);
            logic [CW-1:0] cnt;
            always_ff @(posedge clk) begin
                if (rst)                      cnt <= '0;
                else if (cnt == CW'(DIV - 1)) cnt <= '0;
                else                          cnt <= cnt + 1'b1;
            end
            assign bit_tick = (cnt == CW'(DIV - 1));
        end
    endgenerate
endmodule

// File: rtl/vfd_slot_timer.sv
module vfd_slot_timer #(
    parameter int unsigned SLOT_W = vfd_dim_pkg::SLOT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_tick,
    output logic [SLOT_W-1:0] pos,
    output logic              slot_end
);
    localparam logic [SLOT_W-1:0] LAST_POS = '1;

    always_ff @(posedge clk) begin
        if (rst)           pos <= '0;
        else if (bit_tick) pos <= pos + 1'b1;
    end

    assign slot_end = bit_tick && (pos == LAST_POS);
endmodule

// File: rtl/vfd_grid_rotor.sv
module vfd_grid_rotor
    import vfd_dim_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      slot_end,
    input  logic      duplex_sel,
    output grid_sel_e cur_grid
);
    always_ff @(posedge clk) begin
        if (rst)           cur_grid <= GSEL_1;
        else if (slot_end) cur_grid <= next_grid(cur_grid, duplex_sel);
    end
endmodule

// File: rtl/vfd_pwm_gate.sv
module vfd_pwm_gate #(
    parameter int unsigned W        = vfd_dim_pkg::SLOT_W,
    parameter int unsigned DUTY_MAX = (1 << W) - vfd_dim_pkg::DARK_GAP
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         slot_end,
    input  logic [W-1:0] dim_level,
    input  logic [W-1:0] pos,
    input  logic         blank_n,
    output logic         seg_en
);
    localparam logic [W-1:0] LIM = W'(DUTY_MAX);

    logic [W-1:0] duty_q;

    always_ff @(posedge clk) begin
        if (rst)           duty_q <= '0;
        else if (slot_end) duty_q <= (dim_level > LIM) ? LIM : dim_level;
    end

    assign seg_en = blank_n && (pos < duty_q);
endmodule

// File: rtl/vfd_grid_dimmer.sv
module vfd_grid_dimmer
    import vfd_dim_pkg::*;
#(
    parameter int unsigned CLK_PER_BIT = OSC_PER_BIT,
    parameter int unsigned SLOT_BITS_W = SLOT_W,
    parameter int unsigned GAP_BITS    = DARK_GAP
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   duplex_sel,
    input  logic [SLOT_BITS_W-1:0] dim_level,
    input  logic                   blank_n,
    output logic [2:0]             grid_n,
    output logic                   seg_en,
    output logic [1:0]             grid_idx
);
    localparam int unsigned DUTY_MAX = (1 << SLOT_BITS_W) - GAP_BITS;

    slot_evt_t              evt;
    logic [SLOT_BITS_W-1:0] slot_pos;
    logic                   slot_end;
    grid_sel_e              cur_grid;

    vfd_bit_prescaler #(.DIV(CLK_PER_BIT)) u_pre (
        .clk      (clk),
        .rst      (rst),
        .bit_tick (evt.bit_tick)
    );

    vfd_slot_timer #(.SLOT_W(SLOT_BITS_W)) u_slot (
        .clk      (clk),
        .rst      (rst),
        .bit_tick (evt.bit_tick),
        .pos      (slot_pos),
        .slot_end (evt.slot_end)
    );

    assign slot_end = evt.slot_end;

    vfd_grid_rotor u_rot (
        .clk        (clk),
        .rst        (rst),
        .slot_end   (slot_end),
        .duplex_sel (duplex_sel),
        .cur_grid   (cur_grid)
    );

    vfd_pwm_gate #(.W(SLOT_BITS_W), .DUTY_MAX(DUTY_MAX)) u_pwm (
        .clk       (clk),
        .rst       (rst),
        .slot_end  (slot_end),
        .dim_level (dim_level),
        .pos       (slot_pos),
        .blank_n   (blank_n),
        .seg_en    (seg_en)
    );

    assign grid_n   = grid_strobe_n(cur_grid);
    assign grid_idx = cur_grid;
endmodule

// File: rtl/vfd_grid_dimmer_chk.sv
module vfd_grid_dimmer_chk #(
    parameter int unsigned W        = 10,
    parameter int unsigned DUTY_MAX = 1016
) (
    input logic         clk,
    input logic         rst,
    input logic         duplex_sel,
    input logic         blank_n,
    input logic [2:0]   grid_n,
    input logic [1:0]   grid_idx,
    input logic         seg_en,
    input logic [W-1:0] pos,
    input logic         slot_end
);
    // R4
    grid_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(~grid_n) == 1);

    // R4
    grid_idx_match_chk: assert property (@(posedge clk) disable iff (rst)
        (grid_idx != 2'd3) && !grid_n[grid_idx]);

    // R2
    triplex_step_chk: assert property (@(posedge clk) disable iff (rst)
        (slot_end && !duplex_sel && grid_idx == 2'd1) |=> grid_idx == 2'd2);

    // R3
    duplex_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (slot_end && duplex_sel && grid_idx == 2'd1) |=> grid_idx == 2'd0);

    // R1
    grid_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !slot_end |=> $stable(grid_idx));

    // R7
    dark_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (32'(pos) >= DUTY_MAX) |-> !seg_en);

    // R10
    blank_chk: assert property (@(posedge clk) disable iff (rst)
        !blank_n |-> !seg_en);

    // R5
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (grid_n == 3'b110 && grid_idx == 2'd0 && !seg_en));
endmodule

bind vfd_grid_dimmer vfd_grid_dimmer_chk #(.W(SLOT_BITS_W), .DUTY_MAX(DUTY_MAX)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .duplex_sel (duplex_sel),
    .blank_n    (blank_n),
    .grid_n     (grid_n),
    .grid_idx   (grid_idx),
    .seg_en     (seg_en),
    .pos        (slot_pos),
    .slot_end   (slot_end)
);

// File: tb/tb_vfd_grid_dimmer.sv
module tb_vfd_grid_dimmer;
    localparam int CLK_PERIOD = 10;
    localparam int SLOT_CLK   = 4 * 1024;
    localparam int MAX_CYC    = 200000;

    logic       clk = 1'b0;
    logic       rst;
    logic       duplex_sel;
    logic [9:0] dim_level;
    logic       blank_n;
    logic [2:0] grid_n;
    logic       seg_en;
    logic [1:0] grid_idx;

    vfd_grid_dimmer dut (
        .clk        (clk),
        .rst        (rst),
        .duplex_sel (duplex_sel),
        .dim_level  (dim_level),
        .blank_n    (blank_n),
        .grid_n     (grid_n),
        .seg_en     (seg_en),
        .grid_idx   (grid_idx)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    typedef struct {
        int unsigned cyc;
        logic [2:0]  gn;
        logic [1:0]  gi;
        logic        se;
        logic        chk_grid;
        string       req;
    } exp_t;

    exp_t        sb[$];
    int unsigned ncyc;
    int          n_checks = 0;
    int          n_fail   = 0;
    logic        done     = 1'b0;

    always @(posedge clk) begin
        if (rst) ncyc <= 0;
        else     ncyc <= ncyc + 1;
    end

    function automatic int unsigned at(int slot, int pos);
        return slot * SLOT_CLK + pos * 4 + 2;
    endfunction

    task automatic push(int slot, int pos, logic [2:0] gn, logic [1:0] gi,
                        logic se, logic chk_grid, string req);
        exp_t e;
        e.cyc = at(slot, pos); e.gn = gn; e.gi = gi; e.se = se;
        e.chk_grid = chk_grid; e.req = req;
        sb.push_back(e);
    endtask

    task automatic go_to(int unsigned n);
        while (ncyc < n) begin
            @(posedge clk);
            #1;
        end
    endtask

    // Monitor: pops scoreboard items at their due edge count
    always @(negedge clk) begin
        if (!rst && !done) begin
            while (sb.size() > 0 && sb[0].cyc < ncyc) begin
                n_checks++; n_fail++;
                $display("FAIL %s: item at cycle %0d missed (actual cycle %0d, expected %0d)",
                         sb[0].req, sb[0].cyc, ncyc, sb[0].cyc);
                void'(sb.pop_front());
            end
            if (sb.size() > 0 && sb[0].cyc == ncyc) begin
                exp_t e;
                e = sb.pop_front();
                n_checks++;
                if (seg_en !== e.se ||
                    (e.chk_grid && (grid_n !== e.gn || grid_idx !== e.gi))) begin
                    n_fail++;
                    $display("FAIL %s @cyc %0d: actual grid_n=%b idx=%0d seg=%b expected grid_n=%b idx=%0d seg=%b",
                             e.req, ncyc, grid_n, grid_idx, seg_en, e.gn, e.gi, e.se);
                end
            end
        end
    end

    initial begin
        rst = 1'b1; duplex_sel = 1'b0; dim_level = 10'd100; blank_n = 1'b1;

        // Driver: expectations keyed by slot and bit position
        push(0, 5,    3'b110, 2'd0, 1'b0, 1'b1, "R5 R4 first slot dark");
        push(0, 1023, 3'b110, 2'd0, 1'b0, 1'b1, "R1 slot length");
        push(1, 0,    3'b101, 2'd1, 1'b1, 1'b1, "R1 R2 slot boundary");
        push(1, 99,   3'b101, 2'd1, 1'b1, 1'b0, "R6 last lit bit");
        push(1, 100,  3'b101, 2'd1, 1'b0, 1'b1, "R6 first dark bit");
        push(1, 150,  3'b101, 2'd1, 1'b0, 1'b0, "R9 mid-slot change ignored");
        push(1, 1023, 3'b101, 2'd1, 1'b0, 1'b1, "R9 end of slot");
        push(2, 0,    3'b011, 2'd2, 1'b1, 1'b1, "R2 R4 grid 3 in triplex");
        push(2, 500,  3'b011, 2'd2, 1'b0, 1'b1, "R10 blank forces dark");
        push(2, 700,  3'b011, 2'd2, 1'b1, 1'b0, "R10 unblank");
        push(2, 1015, 3'b011, 2'd2, 1'b1, 1'b0, "R7 clamp last lit");
        push(2, 1016, 3'b011, 2'd2, 1'b0, 1'b0, "R7 clamp first dark");
        push(2, 1023, 3'b011, 2'd2, 1'b0, 1'b1, "R7 dark gap");
        push(3, 0,    3'b110, 2'd0, 1'b0, 1'b1, "R2 R8 wrap and zero duty");
        push(3, 500,  3'b110, 2'd0, 1'b0, 1'b0, "R8 zero duty");
        push(4, 0,    3'b101, 2'd1, 1'b1, 1'b1, "R6 duty one lit");
        push(4, 1,    3'b101, 2'd1, 1'b0, 1'b0, "R6 duty one dark");
        push(5, 0,    3'b110, 2'd0, 1'b1, 1'b1, "R11 R3 duplex wrap");
        push(5, 3,    3'b110, 2'd0, 1'b0, 1'b1, "R3 grid 3 idle");
        push(6, 0,    3'b101, 2'd1, 1'b1, 1'b1, "R3 duplex grid 2");

        repeat (3) @(posedge clk);
        @(negedge clk);
        n_checks++;
        if (grid_n !== 3'b110 || grid_idx !== 2'd0 || seg_en !== 1'b0) begin
            n_fail++;
            $display("FAIL R5 reset: actual grid_n=%b idx=%0d seg=%b expected grid_n=110 idx=0 seg=0",
                     grid_n, grid_idx, seg_en);
        end
        @(posedge clk);
        #1 rst = 1'b0;

        go_to(at(1, 120)); dim_level  = 10'd1023;
        go_to(at(2, 480)); blank_n    = 1'b0;
        go_to(at(2, 580)); blank_n    = 1'b1;
        go_to(at(2, 1018)); dim_level = 10'd0;
        go_to(at(3, 600)); duplex_sel = 1'b1; dim_level = 10'd1;

        while (sb.size() > 0) @(negedge clk);
        #1;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * MAX_CYC);
        if (!done) begin
            done = 1'b1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual pending=%0d expected pending=0", sb.size());
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule